// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Bank

This block holds a small bank of byte-wide mailbox registers that two bus masters share: a local processor port and a host port. Each side reaches the bank through its own 32-bit register port. The port address is a word index, and four byte-lane enables go with it. One side leaves a message in the mailbox bytes and the other side picks it up. Either access can ring a doorbell that the other side sees as an interrupt.

Every mailbox byte has four doorbell sources, each with its own mask:
- a host read, which signals the local side;
- a host write, which signals the local side;
- a local read, which signals the host;
- a local write, which signals the host.

The two read doorbells of a byte set that byte's bit in a read-status register. The two write doorbells set its bit in a write-status register. Software clears status bits by writing ones to them. A single interrupt line is the OR of every status bit, and both sides receive it.

A word access that touches several bytes rings a separate doorbell for each touched byte. Byte lanes limit which bytes count as touched.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, every mailbox byte, every mask bit and every status bit reads as zero, and `irq` is low.
- R2: Mailbox byte `b` sits at word index 0x30 + b/4 (byte offset 0xC0 + b) in lane b%4, which is bits [8*(b%4)+7 : 8*(b%4)]. A write changes only the bytes whose lane enable is 1. Read data appears on the port's rdata after the clock edge that samples the request. Rdata holds its value until the next read. A read returns the contents from before any write at the same edge.
- R3: There are four 16-bit mask registers, with bit i belonging to mailbox byte i. They sit at word indexes 0x34 (host read), 0x35 (host write), 0x36 (local read) and 0x37 (local write). Each is readable and writable from either port in bits [15:0], with lane 0 covering bits [7:0] and lane 1 covering bits [15:8]. A write leaves every mask unchanged except the one it addresses.
- R4: A read of mailbox byte i with its lane enabled sets bit i of the read-status register (word 0x38) at that edge. This happens only if the mask bit for that port's read type is 1. A 0 mask bit leaves the status bit unchanged.
- R5: A write of mailbox byte i with its lane enabled sets bit i of the write-status register (word 0x39) at that edge. This happens only if the mask bit for that port's write type is 1.
- R6: One word access sets one status bit for each enabled lane whose byte has its doorbell unmasked. All of them are set at the same edge.
- R7: Writing 1 to a status bit from either port clears it, and writing 0 leaves it unchanged. Reading the status registers rings no doorbell. If a doorbell and a clear hit the same bit at the same edge, the bit stays set.
- R8: `irq` is high exactly when at least one status bit is set. It follows the status register from the edge that changes it.
- R9: If both ports write the same mailbox byte at the same edge, the byte takes the host value. The enabled write doorbells of both ports still fire.
- R10: Word indexes outside 0x30 to 0x39 read as zero. Writes to them change no mailbox, mask or status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local port access request for this cycle |
| loc_we | input | 1 | Local port: 1 = write, 0 = read |
| loc_addr | input | AW-2 (6) | Local port word index |
| loc_be | input | 4 | Local port byte-lane enables |
| loc_wdata | input | 32 | Local port write data |
| loc_rdata | output | 32 | Local port registered read data |
| host_req | input | 1 | Host port access request for this cycle |
| host_we | input | 1 | Host port: 1 = write, 0 = read |
| host_addr | input | AW-2 (6) | Host port word index |
| host_be | input | 4 | Host port byte-lane enables |
| host_wdata | input | 32 | Host port write data |
| host_rdata | output | 32 | Host port registered read data |
| irq | output | 1 | Combined mailbox interrupt to both sides |

## Verification
All state changes happen at the edge that samples a request. The bench therefore drives each access one time unit after a rising edge and waits for the next edge. It then compares one time unit later:
- read data against the model's contents from before the update;
- `irq` against the OR of the model's updated status bits.

Doorbell, clear and priority effects on status are checked by a read in the following step. That read's data is due one edge after it is issued, so every status result is seen exactly two edges after the access that caused it.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    localparam int LANES     = 4;
    localparam int WORD_W    = 32;
    localparam int NUM_DB    = 4;
    localparam int NUM_PORTS = 2;
    localparam int PORT_LOC  = 0;
    localparam int PORT_HOST = 1;

    // doorbell kinds, index into the mask array
    typedef enum logic [1:0] {
        DB_HOST_RD = 2'd0,
        DB_HOST_WR = 2'd1,
        DB_LOC_RD  = 2'd2,
        DB_LOC_WR  = 2'd3
    } db_kind_e;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NUM_BOX   = 16,
    parameter int MBOX_BASE = 32'hC0,
    parameter int MASK_BASE = 32'hD0,
    parameter int STAT_BASE = 32'hE0
) (
    input  logic                       req,
    input  logic                       we,
    input  logic [AW-3:0]              waddr,
    input  logic [LANES-1:0]           be,
    output logic [NUM_BOX/LANES-1:0]   word_hit,
    output logic [NUM_DB-1:0]          mask_hit,
    output logic                       rstat_hit,
    output logic                       wstat_hit,
    output logic [NUM_BOX-1:0]         box_rd,
    output logic [NUM_BOX-1:0]         box_wr,
    output logic [NUM_DB-1:0]          mask_we,
    output logic [1:0]                 stat_we
);
    localparam int NW = NUM_BOX / LANES;

    logic [NUM_BOX-1:0] touched;
    logic               do_rd;
    logic               do_wr;

    always_comb begin
        do_rd = req && !we;
        do_wr = req && we;
        for (int w = 0; w < NW; w++) begin
            word_hit[w] = (waddr == (AW-2)'((MBOX_BASE >> 2) + w));
        end
        for (int k = 0; k < NUM_DB; k++) begin
            mask_hit[k] = (waddr == (AW-2)'((MASK_BASE >> 2) + k));
        end
        rstat_hit = (waddr == (AW-2)'(STAT_BASE >> 2));
        wstat_hit = (waddr == (AW-2)'((STAT_BASE >> 2) + 1));
        for (int i = 0; i < NUM_BOX; i++) begin
            touched[i] = word_hit[i / LANES] && be[i % LANES];
        end
        box_rd  = do_rd ? touched  : '0;
        box_wr  = do_wr ? touched  : '0;
        mask_we = do_wr ? mask_hit : '0;
        stat_we = do_wr ? {wstat_hit, rstat_hit} : 2'b00;
    end
endmodule

// File: rtl/mbox_store.sv
`timescale 1ns/1ps
module mbox_store
    import mbox_pkg::*;
#(
    parameter int NUM_BOX = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0][NUM_BOX-1:0]    wr_en,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]     wdata,
    output logic [NUM_BOX-1:0][7:0]              bytes_o
);
    typedef struct packed {
        logic [NUM_BOX-1:0][7:0] mem;
    } store_t;

    store_t st_d, st_q;

    // ports walked in ascending order: the host port (index 1) lands last and wins
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int i = 0; i < NUM_BOX; i++) begin
                if (wr_en[p][i]) begin
                    st_d.mem[i] = wdata[p][(i % LANES)*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bytes_o = st_q.mem;
endmodule

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int NUM_BOX = 16,
    parameter int BEW     = (NUM_BOX + 7) / 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0][NUM_BOX-1:0]  box_rd,
    input  logic [NUM_PORTS-1:0][NUM_BOX-1:0]  box_wr,
    input  logic [NUM_PORTS-1:0][NUM_DB-1:0]   mask_we,
    input  logic [NUM_PORTS-1:0][1:0]          stat_we,
    input  logic [NUM_PORTS-1:0][NUM_BOX-1:0]  wdata,
    input  logic [NUM_PORTS-1:0][BEW-1:0]      be,
    output logic [NUM_DB-1:0][NUM_BOX-1:0]     mask_o,
    output logic [NUM_BOX-1:0]                 rstat_o,
    output logic [NUM_BOX-1:0]                 wstat_o,
    output logic                               irq_o
);
    typedef struct packed {
        logic [NUM_DB-1:0][NUM_BOX-1:0] mask;
        logic [NUM_BOX-1:0]             rstat;
        logic [NUM_BOX-1:0]             wstat;
    } ctrl_t;

    ctrl_t              cs_d, cs_q;
    logic [NUM_BOX-1:0] rd_set, wr_set, rd_clr, wr_clr, en;

    always_comb begin
        cs_d   = cs_q;
        // doorbells use the masks held before this edge
        rd_set = (box_rd[PORT_HOST] & cs_q.mask[DB_HOST_RD])
               | (box_rd[PORT_LOC]  & cs_q.mask[DB_LOC_RD]);
        wr_set = (box_wr[PORT_HOST] & cs_q.mask[DB_HOST_WR])
               | (box_wr[PORT_LOC]  & cs_q.mask[DB_LOC_WR]);
        rd_clr = '0;
        wr_clr = '0;
        en     = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < NUM_BOX; b++) begin
                en[b] = be[p][b / 8];
            end
            for (int k = 0; k < NUM_DB; k++) begin
                if (mask_we[p][k]) begin
                    cs_d.mask[k] = (cs_d.mask[k] & ~en) | (wdata[p] & en);
                end
            end
            if (stat_we[p][0]) rd_clr = rd_clr | (wdata[p] & en);
            if (stat_we[p][1]) wr_clr = wr_clr | (wdata[p] & en);
        end
        // a fresh event outranks a clear of the same bit
        cs_d.rstat = (cs_q.rstat & ~rd_clr) | rd_set;
        cs_d.wstat = (cs_q.wstat & ~wr_clr) | wr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign mask_o  = cs_q.mask;
    assign rstat_o = cs_q.rstat;
    assign wstat_o = cs_q.wstat;
    assign irq_o   = |{cs_q.rstat, cs_q.wstat};
endmodule

// File: rtl/mbox_doorbell.sv
`timescale 1ns/1ps
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NUM_BOX   = 16,
    parameter int MBOX_BASE = 32'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic [AW-3:0]     loc_addr,
    input  logic [3:0]        loc_be,
    input  logic [31:0]       loc_wdata,
    output logic [31:0]       loc_rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [AW-3:0]     host_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq
);
    localparam int MASK_BASE = MBOX_BASE + NUM_BOX;
    localparam int STAT_BASE = MASK_BASE + NUM_DB * LANES;
    localparam int NW        = NUM_BOX / LANES;
    localparam int BEW       = (NUM_BOX + 7) / 8;

    logic [NUM_PORTS-1:0]              p_req, p_we;
    logic [NUM_PORTS-1:0][AW-3:0]      p_addr;
    logic [NUM_PORTS-1:0][LANES-1:0]   p_be;
    logic [NUM_PORTS-1:0][WORD_W-1:0]  p_wdata;

    logic [NUM_PORTS-1:0][NW-1:0]      word_hit;
    logic [NUM_PORTS-1:0][NUM_DB-1:0]  mask_hit, mask_we;
    logic [NUM_PORTS-1:0]              rstat_hit, wstat_hit;
    logic [NUM_PORTS-1:0][NUM_BOX-1:0] box_rd, box_wr, ctl_wdata;
    logic [NUM_PORTS-1:0][1:0]         stat_we;
    logic [NUM_PORTS-1:0][BEW-1:0]     ctl_be;

    logic [NUM_BOX-1:0][7:0]           box_bytes;
    logic [NUM_DB-1:0][NUM_BOX-1:0]    mask_q;
    logic [NUM_BOX-1:0]                rstat_q, wstat_q;

    assign p_req   = {host_req,   loc_req};
    assign p_we    = {host_we,    loc_we};
    assign p_addr  = {host_addr,  loc_addr};
    assign p_be    = {host_be,    loc_be};
    assign p_wdata = {host_wdata, loc_wdata};

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        mbox_decode #(
            .AW(AW), .NUM_BOX(NUM_BOX), .MBOX_BASE(MBOX_BASE),
            .MASK_BASE(MASK_BASE), .STAT_BASE(STAT_BASE)
        ) u_dec (
            .req       (p_req[gp]),
            .we        (p_we[gp]),
            .waddr     (p_addr[gp]),
            .be        (p_be[gp]),
            .word_hit  (word_hit[gp]),
            .mask_hit  (mask_hit[gp]),
            .rstat_hit (rstat_hit[gp]),
            .wstat_hit (wstat_hit[gp]),
            .box_rd    (box_rd[gp]),
            .box_wr    (box_wr[gp]),
            .mask_we   (mask_we[gp]),
            .stat_we   (stat_we[gp])
        );
        assign ctl_wdata[gp] = p_wdata[gp][NUM_BOX-1:0];
        assign ctl_be[gp]    = p_be[gp][BEW-1:0];
    end

    mbox_store #(.NUM_BOX(NUM_BOX)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (box_wr),
        .wdata   (p_wdata),
        .bytes_o (box_bytes)
    );

    mbox_ctrl #(.NUM_BOX(NUM_BOX), .BEW(BEW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .box_rd  (box_rd),
        .box_wr  (box_wr),
        .mask_we (mask_we),
        .stat_we (stat_we),
        .wdata   (ctl_wdata),
        .be      (ctl_be),
        .mask_o  (mask_q),
        .rstat_o (rstat_q),
        .wstat_o (wstat_q),
        .irq_o   (irq)
    );

    // registered read data, one word per port
    typedef struct packed {
        logic [NUM_PORTS-1:0][WORD_W-1:0] rdata;
    } rd_t;

    rd_t                rd_d, rd_q;
    logic [WORD_W-1:0]  rv;

    always_comb begin
        rd_d = rd_q;
        rv   = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            rv = '0;
            for (int w = 0; w < NW; w++) begin
                if (word_hit[p][w]) rv = box_bytes[w*LANES +: LANES];
            end
            for (int k = 0; k < NUM_DB; k++) begin
                if (mask_hit[p][k]) rv[NUM_BOX-1:0] = mask_q[k];
            end
            if (rstat_hit[p]) rv[NUM_BOX-1:0] = rstat_q;
            if (wstat_hit[p]) rv[NUM_BOX-1:0] = wstat_q;
            if (p_req[p] && !p_we[p]) rd_d.rdata[p] = rv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign loc_rdata  = rd_q.rdata[PORT_LOC];
    assign host_rdata = rd_q.rdata[PORT_HOST];
endmodule

// File: rtl/mbox_doorbell_chk.sv
`timescale 1ns/1ps
module mbox_doorbell_chk
    import mbox_pkg::*;
#(
    parameter int NUM_BOX = 16
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               loc_req,
    input logic                               loc_we,
    input logic [31:0]                        loc_rdata,
    input logic                               host_req,
    input logic                               host_we,
    input logic [31:0]                        host_rdata,
    input logic [NUM_PORTS-1:0][NUM_BOX-1:0]  box_rd,
    input logic [NUM_PORTS-1:0][NUM_BOX-1:0]  box_wr,
    input logic [NUM_DB-1:0][NUM_BOX-1:0]     mask,
    input logic [NUM_BOX-1:0]                 rstat,
    input logic [NUM_BOX-1:0]                 wstat,
    input logic                               irq
);
    logic [NUM_BOX-1:0] exp_rd_set, exp_wr_set;

    assign exp_rd_set = (box_rd[PORT_HOST] & mask[0]) | (box_rd[PORT_LOC] & mask[2]);
    assign exp_wr_set = (box_wr[PORT_HOST] & mask[1]) | (box_wr[PORT_LOC] & mask[3]);

    // R4: an enabled read doorbell is latched at the next edge
    p_rd_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rstat & $past(exp_rd_set)) == $past(exp_rd_set)));

    // R5: an enabled write doorbell is latched at the next edge
    p_wr_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((wstat & $past(exp_wr_set)) == $past(exp_wr_set)));

    // R7: no status bit turns on without a doorbell behind it
    p_no_spurious_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rstat & ~$past(rstat) & ~$past(exp_rd_set)) == '0));
    p_no_spurious_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((wstat & ~$past(wstat) & ~$past(exp_wr_set)) == '0));

    // R8: the interrupt only rises after a doorbell
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(exp_rd_set | exp_wr_set)));

    // R2: read data holds when no read was requested
    p_loc_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_req && !loc_we) |=> $stable(loc_rdata));
    p_host_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> $stable(host_rdata));

    // R3: masks move only under a write
    p_mask_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(loc_req && loc_we) && !(host_req && host_we)) |=> $stable(mask));
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.NUM_BOX(NUM_BOX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_req    (loc_req),
    .loc_we     (loc_we),
    .loc_rdata  (loc_rdata),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .box_rd     (box_rd),
    .box_wr     (box_wr),
    .mask       (mask_q),
    .rstat      (rstat_q),
    .wstat      (wstat_q),
    .irq        (irq)
);

// File: tb/mbox_doorbell_test.sv
`timescale 1ns/1ps
module mbox_doorbell_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        loc_req, loc_we, host_req, host_we;
    logic [5:0]  loc_addr, host_addr;
    logic [3:0]  loc_be, host_be;
    logic [31:0] loc_wdata, host_wdata, loc_rdata, host_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the bank
    logic [7:0]  mb [16];
    logic [15:0] mm [4];
    logic [15:0] rs, ws;

    always #10 clk = ~clk;   // 50 MHz

    mbox_doorbell uut (
        .clk(clk), .rst_n(rst_n),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_be(loc_be),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq)
    );

    function automatic logic [15:0] en16(input logic [3:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] touched(input logic [5:0] wa, input logic [3:0] be);
        logic [15:0] t = '0;
        if (wa >= 6'h30 && wa <= 6'h33)
            for (int j = 0; j < 4; j++) t[(int'(wa) - 48)*4 + j] = be[j];
        return t;
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] wa);
        if (wa >= 6'h30 && wa <= 6'h33) begin
            int b = (int'(wa) - 48) * 4;
            return {mb[b+3], mb[b+2], mb[b+1], mb[b]};
        end
        if (wa >= 6'h34 && wa <= 6'h37) return {16'h0, mm[int'(wa) - 52]};
        if (wa == 6'h38) return {16'h0, rs};
        if (wa == 6'h39) return {16'h0, ws};
        return 32'h0;
    endfunction

    function automatic string region(input logic [5:0] wa);
        if (wa >= 6'h30 && wa <= 6'h33) return "R2";
        if (wa >= 6'h34 && wa <= 6'h37) return "R3";
        if (wa == 6'h38 || wa == 6'h39) return "R7";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                               inout logic [15:0] rclr, inout logic [15:0] wclr);
        logic [15:0] t;
        t = touched(a, be);
        for (int i = 0; i < 16; i++) if (t[i]) mb[i] = d[(i % 4)*8 +: 8];
        if (a >= 6'h34 && a <= 6'h37)
            mm[int'(a) - 52] = (mm[int'(a) - 52] & ~en16(be)) | (d[15:0] & en16(be));
        if (a == 6'h38) rclr |= d[15:0] & en16(be);
        if (a == 6'h39) wclr |= d[15:0] & en16(be);
    endtask

    // one access cycle on both ports; outputs checked after the sampling edge
    task automatic step(input logic lr, input logic lw, input logic [5:0] la, input logic [3:0] lbe,
                        input logic [31:0] lwd,
                        input logic hr, input logic hw, input logic [5:0] ha, input logic [3:0] hbe,
                        input logic [31:0] hwd, input string tag);
        logic [31:0] exp_l, exp_h;
        logic [15:0] rset, wset, rclr, wclr;
        loc_req = lr;  loc_we = lw;  loc_addr = la;  loc_be = lbe;  loc_wdata = lwd;
        host_req = hr; host_we = hw; host_addr = ha; host_be = hbe; host_wdata = hwd;
        exp_l = model_read(la);
        exp_h = model_read(ha);
        rset = '0; wset = '0; rclr = '0; wclr = '0;
        if (hr && !hw) rset |= touched(ha, hbe) & mm[0];
        if (hr &&  hw) wset |= touched(ha, hbe) & mm[1];
        if (lr && !lw) rset |= touched(la, lbe) & mm[2];
        if (lr &&  lw) wset |= touched(la, lbe) & mm[3];
        if (lr && lw) apply_write(la, lbe, lwd, rclr, wclr);
        if (hr && hw) apply_write(ha, hbe, hwd, rclr, wclr);   // host last: wins (R9)
        rs = (rs & ~rclr) | rset;
        ws = (ws & ~wclr) | wset;
        @(posedge clk);
        #1;
        if (lr && !lw) check((tag != "") ? tag : region(la), loc_rdata, exp_l);
        if (hr && !hw) check((tag != "") ? tag : region(ha), host_rdata, exp_h);
        check("R8", {31'h0, irq}, {31'h0, |{rs, ws}});
    endtask

    task automatic idle();
        step(0, 0, 6'h0, 4'h0, 32'h0, 0, 0, 6'h0, 4'h0, 32'h0, "");
    endtask

    function automatic logic [5:0] pick_addr(input int r);
        case (r)
            0, 1, 2, 3, 4, 5, 6, 7: return 6'h30 + 6'(r % 4);
            8, 9, 10, 11:           return 6'h34 + 6'(r - 8);
            12, 13, 14:             return 6'h38;
            15, 16:                 return 6'h39;
            17:                     return 6'h3A;
            default:                return 6'h00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        rst_n = 1'b0;
        loc_req = 0; loc_we = 0; loc_addr = '0; loc_be = '0; loc_wdata = '0;
        host_req = 0; host_we = 0; host_addr = '0; host_be = '0; host_wdata = '0;
        for (int i = 0; i < 16; i++) mb[i] = 8'h0;
        for (int k = 0; k < 4; k++) mm[k] = 16'h0;
        rs = '0; ws = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents through both ports
        check("R1", {31'h0, irq}, 32'h0);
        for (int a = 6'h30; a <= 6'h39; a++)
            step(1, 0, 6'(a), 4'hF, 0, 1, 0, 6'(a), 4'hF, 0, "R1");

        // R3: program the four masks from alternating ports, read them back
        step(1, 1, 6'h34, 4'hF, 32'h0000FFFF, 1, 1, 6'h35, 4'hF, 32'h0000FFFF, "");
        step(1, 1, 6'h36, 4'hF, 32'h0000FFFF, 1, 1, 6'h37, 4'h1, 32'h0000FFFF, "");
        step(1, 0, 6'h37, 4'hF, 0, 1, 0, 6'h36, 4'hF, 0, "R3");
        step(0, 0, 6'h0, 4'h0, 0, 1, 1, 6'h37, 4'h2, 32'h0000FF00, "");

        // R6: one host word read rings four doorbells
        step(0, 0, 6'h0, 4'h0, 0, 1, 0, 6'h31, 4'hF, 0, "R6");
        step(1, 0, 6'h38, 4'hF, 0, 0, 0, 6'h0, 4'h0, 0, "R6");

        // R4: masked bytes do not ring
        step(1, 1, 6'h38, 4'hF, 32'hFFFF, 1, 1, 6'h34, 4'hF, 32'h0001, "");
        step(0, 0, 6'h0, 4'h0, 0, 1, 0, 6'h30, 4'hF, 0, "");
        step(1, 0, 6'h38, 4'hF, 0, 0, 0, 6'h0, 4'h0, 0, "R4");

        // R5: single-lane local write rings one write doorbell
        step(1, 1, 6'h32, 4'b0010, 32'h0000_5A00, 0, 0, 6'h0, 4'h0, 0, "");
        step(0, 0, 6'h0, 4'h0, 0, 1, 0, 6'h39, 4'hF, 0, "R5");

        // R9: same-byte write collision
        step(1, 1, 6'h39, 4'hF, 32'hFFFF, 0, 0, 6'h0, 4'h0, 0, "");
        step(1, 1, 6'h30, 4'b0001, 32'h11, 1, 1, 6'h30, 4'b0001, 32'h22, "");
        step(1, 0, 6'h30, 4'hF, 0, 1, 0, 6'h39, 4'hF, 0, "R9");

        // R7: clear and fresh event on the same bit; event wins
        step(1, 1, 6'h39, 4'hF, 32'hFFFF, 1, 1, 6'h30, 4'b0001, 32'h33, "");
        step(1, 0, 6'h39, 4'hF, 0, 0, 0, 6'h0, 4'h0, 0, "R7");
        step(1, 1, 6'h38, 4'hF, 32'hFFFF, 1, 1, 6'h39, 4'hF, 32'hFFFF, "");
        step(1, 0, 6'h38, 4'hF, 0, 1, 0, 6'h39, 4'hF, 0, "R7");
        step(1, 0, 6'h38, 4'hF, 0, 1, 0, 6'h38, 4'hF, 0, "R7");

        // R10: unmapped writes and reads
        step(1, 1, 6'h00, 4'hF, 32'hDEADBEEF, 1, 1, 6'h3F, 4'hF, 32'hFFFFFFFF, "");
        step(1, 0, 6'h3A, 4'hF, 0, 1, 0, 6'h00, 4'hF, 0, "R10");
        step(1, 0, 6'h37, 4'hF, 0, 1, 0, 6'h39, 4'hF, 0, "R10");

        // R2: partial-lane write and read-before-write at the same edge
        step(1, 1, 6'h33, 4'b0101, 32'hAABBCCDD, 0, 0, 6'h0, 4'h0, 0, "");
        step(1, 1, 6'h33, 4'hF, 32'h01020304, 1, 0, 6'h33, 4'hF, 0, "R2");
        step(1, 0, 6'h33, 4'hF, 0, 0, 0, 6'h0, 4'h0, 0, "R2");
        idle();

        // constrained random traffic on both ports
        for (int n = 0; n < 4000; n++) begin
            logic [5:0]  a0, a1;
            logic [31:0] d0, d1;
            logic        w0, w1;
            a0 = pick_addr($urandom % 19);
            a1 = pick_addr($urandom % 19);
            w0 = ($urandom % 3) == 0;
            w1 = ($urandom % 3) == 0;
            d0 = $urandom;
            d1 = $urandom;
            if (a0 >= 6'h38 && ($urandom % 2) == 0) d0 = 32'hFFFF;
            if (a1 >= 6'h38 && ($urandom % 2) == 0) d1 = 32'hFFFF;
            step(($urandom % 4) != 0, w0, a0, 4'($urandom), d0,
                 ($urandom % 4) != 0, w1, a1, 4'($urandom), d1, "");
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule